// File: doc/BRIEF.md
# IrDA SIR Pulse Decoder

This block turns the short infrared pulses of a serial IR link back into the NRZ data stream that an ordinary UART receiver expects. The IR receive line is first brought into the system clock domain through a flop synchronizer. Each rising edge found on the synchronized line is taken as the sign of a zero bit. That edge produces one low data bit, one full bit time long, on the decoded output.

Timing comes from a 16x bit-rate clock enable, `tick_16x`, which is supplied alongside the system clock. A detected edge arms the decoder. The next tick drives the output low. A 4-bit counter then counts sixteen ticks before the output returns high. Edges that arrive while a bit is being produced are discarded. When no pulses arrive, the output idles high, which a UART reads as line idle and stop bits.

Top module: `sir_pulse_decoder`

## Requirements
- R1: On reset the decoded output `rx_nrz` is 1 and the tick counter is 0, so the first window after reset is a full 16 ticks long.
- R2: A 0-to-1 change of `ir_rx` reaches the edge detector after two synchronizer flops and arms the decoder on the third clock edge. `rx_nrz` then goes to 0 on the first clock edge after that where `tick_16x` is 1.
- R3: Once low, `rx_nrz` stays 0 for exactly 16 clock edges with `tick_16x` high. It returns to 1 on the 16th such edge.
- R4: While `ir_rx` shows no 0-to-1 change, `rx_nrz` stays 1 for any number of cycles and ticks.
- R5: A rising edge seen while the decoder is armed or producing a low bit is ignored. It neither extends nor restarts the current window, and it does not queue a second window.
- R6: The window counter advances only on clock edges with `tick_16x` high and holds its value otherwise.
- R7: Holding `ir_rx` at 1 produces only the single window caused by its rising edge. The high level itself never retriggers the decoder.
- R8: Driving `rst_n` to 0 forces `rx_nrz` to 1 at once, without waiting for a clock edge, even in the middle of a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| tick_16x | input | 1 | Clock enable at 16 times the bit rate |
| ir_rx | input | 1 | Raw infrared receive line, asynchronous to clk |
| rx_nrz | output | 1 | Reconstructed NRZ receive data, idle high |

## Verification
The hardest situation to reach is a new edge landing in the narrow gaps of the decoder's life cycle. Such gaps are the cycles between arming and the first tick, and the very edge on which the window closes. There the ignore rule and the window end interact. The random phase places short pulses of 1 to 5 clocks at random gaps, with ticks at random density, so edges fall in every phase of the window. A cycle-level reference model in the bench flags any early, late or repeated window. A separate tick counter confirms that every completed window spans exactly sixteen ticks.

// File: rtl/sir_dec_pkg.sv
package sir_dec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LOW   = 2'd2
  } dec_state_e;

endpackage

// File: rtl/sir_rst_sync.sv
module sir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/sir_sync.sv
module sir_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], d_async};
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/sir_edge_det.sv
module sir_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/sir_stretch.sv
module sir_stretch
  import sir_dec_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rise_i,
  output logic nrz_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  dec_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rise_i) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (tick_i) begin
          state_d = ST_LOW;
          cnt_d   = '0;
        end
      end
      ST_LOW: begin
        if (tick_i) begin
          if (cnt_q == CNT_MAX) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign nrz_o = (state_q != ST_LOW);

  AST_CNT_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q)); // R6
  AST_CNT_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_LOW) |-> (cnt_q == '0)); // R1
  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nrz_o) |-> ($past(tick_i) && $past(state_q) == ST_ARMED)); // R2
  AST_RISE_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nrz_o) |-> ($past(tick_i) && $past(cnt_q) == CNT_MAX)); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOW && tick_i && cnt_q != CNT_MAX) |=>
      (state_q == ST_LOW && cnt_q == $past(cnt_q) + 1'b1)); // R5
  AST_ARM_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && $past(state_q) == ST_IDLE) |-> $past(rise_i)); // R4

endmodule

// File: rtl/sir_pulse_decoder.sv
module sir_pulse_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_16x,
  input  logic ir_rx,
  output logic rx_nrz
);

  logic rst_n_int;
  logic ir_sync;
  logic ir_rise;

  sir_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  sir_sync #(.STAGES(SYNC_STAGES)) u_ir_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .d_async (ir_rx),
    .q_sync  (ir_sync)
  );

  sir_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .level_i (ir_sync),
    .rise_o  (ir_rise)
  );

  sir_stretch #(.CNT_W(CNT_W)) u_stretch (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .tick_i (tick_16x),
    .rise_i (ir_rise),
    .nrz_o  (rx_nrz)
  );

  AST_RESET_HIGH: assert property (@(posedge clk)
    !rst_n_int |-> rx_nrz); // R8

endmodule

// File: tb/sir_pulse_decoder_test.sv
module sir_pulse_decoder_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_16x = 1'b0;
  logic ir_rx = 1'b0;
  logic rx_nrz;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sir_pulse_decoder uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_16x (tick_16x),
    .ir_rx    (ir_rx),
    .rx_nrz   (rx_nrz)
  );

  // reference model built from the requirements
  logic m_s1, m_s2, m_prev, m_armed, m_low;
  int   m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_armed <= 0; m_low <= 0; m_cnt <= 0;
    end else begin
      m_s1 <= ir_rx; m_s2 <= m_s1; m_prev <= m_s2;
      if (m_low) begin
        if (tick_16x) begin
          if (m_cnt == 15) begin m_low <= 0; m_cnt <= 0; end
          else m_cnt <= m_cnt + 1;
        end
      end else if (m_armed) begin
        if (tick_16x) begin m_armed <= 0; m_low <= 1; m_cnt <= 0; end
      end else if (m_s2 && !m_prev) begin
        m_armed <= 1;
      end
    end
  end

  function automatic logic expected_nrz();
    return !m_low;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rx_nrz=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // independent window-length measurement (R3)
  logic prev_rx = 1'b1;
  logic last_tick = 1'b0;
  int   low_ticks = 0;
  int   windows = 0;

  task automatic step(input string req, input logic ir, input logic tk);
    @(negedge clk);
    check(req, rx_nrz, expected_nrz());
    if (prev_rx == 1'b0 && last_tick) low_ticks++;
    if (prev_rx == 1'b0 && rx_nrz == 1'b1) begin
      windows++;
      checks++;
      if (low_ticks != 16) begin
        errors++;
        $display("FAIL R3: window ticks=%0d expected 16", low_ticks);
      end
      low_ticks = 0;
    end
    if (rx_nrz == 1'b1) low_ticks = 0;
    prev_rx = rx_nrz;
    last_tick = tk;
    ir_rx = ir;
    tick_16x = tk;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    int w0;
    int w1;
    void'($urandom(32'd1234));
    // R1: reset state
    for (int i = 0; i < 4; i++) step("R1", 1'b0, i[0]);
    check("R1", rx_nrz, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step("R1", 1'b0, 1'b0);

    // R4: long idle with ticks, no edges
    for (int i = 0; i < 300; i++) step("R4", 1'b0, (i % 3) == 0);
    check("R4", rx_nrz, 1'b1);

    // R2/R3/R6: single pulse, sparse ticks
    step("R2", 1'b1, 1'b0);
    step("R2", 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step("R2", 1'b0, 1'b0);
    check("R2", rx_nrz, 1'b1);          // armed, no tick yet
    step("R2", 1'b0, 1'b1);
    step("R2", 1'b0, 1'b0);
    check("R2", rx_nrz, 1'b0);          // low after first tick
    for (int i = 0; i < 200; i++) step("R6", 1'b0, (i % 7) == 3);

    // R5: extra edges inside window
    w0 = windows;
    step("R5", 1'b1, 1'b0);
    for (int i = 0; i < 90; i++) step("R5", (i % 10) < 2, (i % 4) == 0);
    for (int i = 0; i < 40; i++) step("R5", 1'b0, 1'b1);
    w1 = windows;
    checks++;
    if (w1 - w0 < 1) begin
      errors++;
      $display("FAIL R5: windows=%0d expected >=1", w1 - w0);
    end

    // R7: level held high
    w0 = windows;
    for (int i = 0; i < 120; i++) step("R7", 1'b1, 1'b1);
    check("R7", rx_nrz, 1'b1);
    checks++;
    if (windows - w0 != 1) begin
      errors++;
      $display("FAIL R7: windows=%0d expected 1", windows - w0);
    end
    for (int i = 0; i < 5; i++) step("R7", 1'b0, 1'b0);

    // R8: asynchronous reset mid-window
    step("R8", 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) step("R8", 1'b0, 1'b1);
    check("R8", rx_nrz, 1'b0);
    #2 rst_n = 1'b0;
    #1 check("R8", rx_nrz, 1'b1);
    prev_rx = 1'b1; low_ticks = 0;
    for (int i = 0; i < 3; i++) step("R8", 1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step("R1", 1'b0, 1'b1);
    // R1: full window after reset
    w0 = windows;
    step("R1", 1'b1, 1'b0);
    for (int i = 0; i < 60; i++) step("R1", 1'b0, 1'b1);
    checks++;
    if (windows - w0 != 1) begin
      errors++;
      $display("FAIL R1: windows=%0d expected 1", windows - w0);
    end

    // random phase: R2 R3 R5 R6
    for (int n = 0; n < 3000; n++) begin
      int gap = $urandom_range(0, 40);
      int wid = $urandom_range(1, 5);
      int dens = $urandom_range(1, 6);
      for (int i = 0; i < wid; i++) step("R5", 1'b1, ($urandom_range(0, dens) == 0));
      for (int i = 0; i < gap; i++) step("R3", 1'b0, ($urandom_range(0, dens) == 0));
    end
    for (int i = 0; i < 60; i++) step("R3", 1'b0, 1'b1);
    finish_run();
  end

endmodule